// File: doc/BRIEF.md
# Hexagonal Stimulation Phase Scheduler

This block sequences one frame of stimulation for a hexagonal grid of 98 electrodes. The grid has 7 rows of 14 sites and uses axial coordinates (q, r). The electrode index is r*14 + q. Every site is given a colour, (q + 3r) mod 7, and the frame runs through seven phases, one per colour. In a phase, every site of that colour acts as a centre. Any site that has a centre in one of its six lattice neighbours acts as a current-return guard. All other sites stay idle. Sites on the edge of the grid are not wrapped, so a neighbour that lies outside the grid does not exist.

Each phase opens with a fetch window. In that window the block reads the amplitude of each of the 14 centres from an external intensity RAM, which has one cycle of read latency, and forwards each value as a tagged stream item. The centre then receives a biphasic pulse with three parts: cathodic, then a gap, then anodic. The length of each part comes from its own count input. A frame-start pulse starts phase 0 from idle. If a frame-start arrives during a frame, the current phase still runs to the end of its anodic part, and only then does the block restart at phase 0. This keeps the charge balanced.

Top module: `hex_stim_scheduler`

## Requirements
- R1: During and after reset, with no frame started: pulse_o is 0, every role is idle, amp_rd_o is 0 and amp_vld_o is 0.
- R2: When sof_i is sampled high while idle, the next cycle starts the fetch window of phase 0 (phase_o = 0).
- R3: role_o[2i+1:2i] is the role of electrode i = r*14 + q. Code 00 means idle, 01 centre and 10 guard. During phase p, electrode i is a centre exactly when (q + 3r) mod 7 = p.
- R4: During a phase, a non-centre electrode is a guard when any of its in-grid neighbours is a centre. The neighbours are (q±1, r), (q, r±1), (q+1, r−1) and (q−1, r+1), with no wrap-around. Otherwise it is idle. Outside a frame, all roles are idle.
- R5: Every phase begins with a fetch window of 15 cycles. In the first 14 cycles, amp_rd_o is 1 and amp_addr_o gives the indices of that phase's centres in ascending order. In the last cycle, and outside fetch windows, amp_rd_o is 0.
- R6: One cycle after each read, amp_vld_o is 1, amp_idx_o holds the address that was read and amp_o carries amp_data_i. No other items appear.
- R7: After the fetch window, pulse_o is 1 (cathodic) for cath_len_i cycles, then 2 (gap) for gap_len_i cycles, then 3 (anodic) for anod_len_i cycles. A length of 0 acts as 1. At all other times pulse_o is 0.
- R8: The phases run 0 through 6 in order, shown on phase_o. After the anodic part of phase 6, the block returns to idle.
- R9: A sof_i that arrives during a frame, in any part of any phase, lets the current phase finish its anodic part. The fetch window of phase 0 follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Frame-start pulse |
| cath_len_i | input | 16 | Cathodic length in cycles |
| gap_len_i | input | 16 | Inter-phase gap length in cycles |
| anod_len_i | input | 16 | Anodic length in cycles |
| amp_data_i | input | 8 | Intensity RAM read data, one cycle after the address |
| amp_rd_o | output | 1 | Intensity RAM read strobe |
| amp_addr_o | output | 7 | Intensity RAM read address (electrode index) |
| amp_vld_o | output | 1 | Amplitude stream item valid |
| amp_idx_o | output | 7 | Electrode index of the stream item |
| amp_o | output | 8 | Amplitude of the stream item |
| pulse_o | output | 2 | Pulse state: 0 off, 1 cathodic, 2 gap, 3 anodic |
| phase_o | output | 3 | Current phase number |
| role_o | output | 196 | Two-bit role per electrode |

## Verification
Because the state is registered, the fetch window of phase 0 becomes visible one cycle after the edge that samples sof_i. The bench therefore raises sof_i for one cycle and then checks every cycle from 0 to 14 + cathodic + gap + anodic against the expected pulse code, phase number, read strobe and full role vector. A stream item appears one cycle after its read. A scoreboard holds the expected index and amplitude items for each phase, pushed in advance, and a monitor pops one at each sampled cycle that has amp_vld_o set. A mid-frame sof_i is raised on a known cycle within a phase, and the cycle walk expects the restart only after that phase's last anodic cycle. All checks sample on the falling edge.

// File: rtl/hexsched_pkg.sv
package hexsched_pkg;

    localparam int NPH = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CATH,
        ST_GAP,
        ST_ANOD
    } sched_state_e;

    typedef enum logic [1:0] {
        PULSE_OFF  = 2'd0,
        PULSE_CATH = 2'd1,
        PULSE_GAP  = 2'd2,
        PULSE_ANOD = 2'd3
    } pulse_e;

    localparam logic [1:0] ROLE_IDLE = 2'b00;
    localparam logic [1:0] ROLE_CTR  = 2'b01;
    localparam logic [1:0] ROLE_GRD  = 2'b10;

endpackage

// File: rtl/hex_phase_seq.sv
module hex_phase_seq
    import hexsched_pkg::*;
#(
    parameter int TW   = 16,
    parameter int NCTR = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_i,
    input  logic [TW-1:0]      cath_len_i,
    input  logic [TW-1:0]      gap_len_i,
    input  logic [TW-1:0]      anod_len_i,
    output sched_state_e       state_o,
    output logic [2:0]         phase_o,
    output logic [TW-1:0]      slot_o,
    output logic               fetch_o
);

    localparam logic [TW-1:0] LOAD_LAST = TW'(NCTR);
    localparam logic [2:0]    LAST_PH   = 3'(NPH - 1);

    typedef struct packed {
        sched_state_e  st;
        logic [2:0]    ph;
        logic [TW-1:0] cnt;
        logic          pend;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic span_done(input logic [TW-1:0] c, input logic [TW-1:0] len);
        return ({1'b0, c} + {{TW{1'b0}}, 1'b1}) >= {1'b0, len};
    endfunction

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (sof_i) begin
                    s_d.st   = ST_LOAD;
                    s_d.ph   = '0;
                    s_d.cnt  = '0;
                    s_d.pend = 1'b0;
                end
            end
            ST_LOAD: begin
                s_d.pend = s_q.pend | sof_i;
                if (s_q.cnt == LOAD_LAST) begin
                    s_d.st  = ST_CATH;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_CATH: begin
                s_d.pend = s_q.pend | sof_i;
                if (span_done(s_q.cnt, cath_len_i)) begin
                    s_d.st  = ST_GAP;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                s_d.pend = s_q.pend | sof_i;
                if (span_done(s_q.cnt, gap_len_i)) begin
                    s_d.st  = ST_ANOD;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_ANOD: begin
                if (span_done(s_q.cnt, anod_len_i)) begin
                    s_d.cnt = '0;
                    if (s_q.pend | sof_i) begin
                        s_d.st   = ST_LOAD;
                        s_d.ph   = '0;
                        s_d.pend = 1'b0;
                    end else if (s_q.ph == LAST_PH) begin
                        s_d.st   = ST_IDLE;
                        s_d.pend = 1'b0;
                    end else begin
                        s_d.st = ST_LOAD;
                        s_d.ph = s_q.ph + 1'b1;
                    end
                end else begin
                    s_d.cnt  = s_q.cnt + 1'b1;
                    s_d.pend = s_q.pend | sof_i;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ph: 3'd0, cnt: '0, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q.st;
    assign phase_o = s_q.ph;
    assign slot_o  = s_q.cnt;
    assign fetch_o = (s_q.st == ST_LOAD) && (s_q.cnt < LOAD_LAST);

    // R7: cathodic leads only into the gap
    a_r7_cath_to_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_CATH) |=> (s_q.st == ST_CATH || s_q.st == ST_GAP));

    // R7: the gap leads only into the anodic part
    a_r7_gap_to_anod: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_GAP) |=> (s_q.st == ST_GAP || s_q.st == ST_ANOD));

    // R9: a phase is left only from its anodic part
    a_r9_exit_from_anod: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ANOD) |=> (s_q.st == ST_ANOD || s_q.st == ST_LOAD || s_q.st == ST_IDLE));

    // R8: a new phase is either the next one or a restart at 0
    a_r8_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_LOAD && $past(s_q.st) == ST_ANOD) |->
        (s_q.ph == 3'd0 || s_q.ph == $past(s_q.ph) + 3'd1));

    // R8: the frame ends only after the last phase
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && $past(s_q.st) == ST_ANOD) |-> ($past(s_q.ph) == LAST_PH));

endmodule

// File: rtl/hex_amp_fetch.sv
module hex_amp_fetch
    import hexsched_pkg::*;
#(
    parameter int ROWS = 7,
    parameter int REPS = 2,
    parameter int TW   = 16,
    parameter int AW   = 8,
    parameter int IW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_i,
    input  logic [2:0]    phase_i,
    input  logic [TW-1:0] slot_i,
    input  logic [AW-1:0] amp_data_i,
    output logic          amp_rd_o,
    output logic [IW-1:0] amp_addr_o,
    output logic          amp_vld_o,
    output logic [IW-1:0] amp_idx_o,
    output logic [AW-1:0] amp_o
);

    localparam int COLS = NPH * REPS;
    localparam int N    = ROWS * COLS;

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } pipe_t;

    pipe_t p_d, p_q;

    function automatic logic [IW-1:0] centre_addr(input logic [2:0] p, input logic [TW-1:0] k);
        int kk, r, j, q;
        kk = int'(k);
        r  = kk / REPS;
        j  = kk % REPS;
        q  = ((int'(p) + NPH - ((3 * r) % NPH)) % NPH) + NPH * j;
        return IW'(r * COLS + q);
    endfunction

    always_comb begin
        amp_rd_o   = fetch_i;
        amp_addr_o = fetch_i ? centre_addr(phase_i, slot_i) : '0;
        p_d.vld    = fetch_i;
        p_d.idx    = amp_addr_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign amp_vld_o = p_q.vld;
    assign amp_idx_o = p_q.idx;
    assign amp_o     = p_q.vld ? amp_data_i : '0;

    // R5: read addresses stay inside the array
    a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        amp_rd_o |-> (int'(amp_addr_o) < N));

    // R6: each read yields a stream item one cycle later, tagged with its address
    a_r6_item_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        amp_rd_o |=> (amp_vld_o && amp_idx_o == $past(amp_addr_o)));

    // R6: no item without a read
    a_r6_no_stray_item: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_rd_o |=> !amp_vld_o);

endmodule

// File: rtl/hex_role_map.sv
module hex_role_map
    import hexsched_pkg::*;
#(
    parameter int ROWS = 7,
    parameter int REPS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              active_i,
    input  logic [2:0]                        phase_i,
    output logic [2*ROWS*NPH*REPS-1:0]        role_o
);

    localparam int COLS = NPH * REPS;
    localparam int N    = ROWS * COLS;
    localparam int NCTR = ROWS * REPS;

    logic [N-1:0] ctr_mask;

    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
        for (genvar gq = 0; gq < COLS; gq++) begin : g_col
            localparam int IDX = gr * COLS + gq;
            localparam int CLR = (gq + 3 * gr) % NPH;
            // bit d set when the neighbour whose colour is this colour + d exists
            localparam logic [6:0] NB = {
                1'(gq > 0),                      // d=6: (q-1, r)
                1'((gq < COLS - 1) && (gr > 0)), // d=5: (q+1, r-1)
                1'(gr > 0),                      // d=4: (q, r-1)
                1'(gr < ROWS - 1),               // d=3: (q, r+1)
                1'((gq > 0) && (gr < ROWS - 1)), // d=2: (q-1, r+1)
                1'(gq < COLS - 1),               // d=1: (q+1, r)
                1'b0
            };
            logic [3:0] sm;
            logic [2:0] dd;
            assign sm = {1'b0, phase_i} + 4'(NPH - CLR);
            assign dd = (sm >= 4'd7) ? 3'(sm - 4'd7) : sm[2:0];
            assign ctr_mask[IDX] = active_i && (dd == 3'd0);
            assign role_o[2*IDX +: 2] = !active_i   ? ROLE_IDLE :
                                        (dd == 3'd0) ? ROLE_CTR  :
                                        NB[dd]       ? ROLE_GRD  : ROLE_IDLE;
        end
    end

    // R3: each active phase has exactly one centre per colour slot
    a_r3_centre_count: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> ($countones(ctr_mask) == NCTR));

    // R4: outside a frame every electrode is idle
    a_r4_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> (role_o == '0));

endmodule

// File: rtl/hex_stim_scheduler.sv
module hex_stim_scheduler
    import hexsched_pkg::*;
#(
    parameter int ROWS = 7,
    parameter int REPS = 2,
    parameter int TW   = 16,
    parameter int AW   = 8,
    localparam int COLS = NPH * REPS,
    localparam int N    = ROWS * COLS,
    localparam int IW   = $clog2(N),
    localparam int NCTR = ROWS * REPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic [TW-1:0]     cath_len_i,
    input  logic [TW-1:0]     gap_len_i,
    input  logic [TW-1:0]     anod_len_i,
    input  logic [AW-1:0]     amp_data_i,
    output logic              amp_rd_o,
    output logic [IW-1:0]     amp_addr_o,
    output logic              amp_vld_o,
    output logic [IW-1:0]     amp_idx_o,
    output logic [AW-1:0]     amp_o,
    output logic [1:0]        pulse_o,
    output logic [2:0]        phase_o,
    output logic [2*N-1:0]    role_o
);

    sched_state_e  state;
    logic [2:0]    phase;
    logic [TW-1:0] slot;
    logic          fetch;

    hex_phase_seq #(.TW(TW), .NCTR(NCTR)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .cath_len_i (cath_len_i),
        .gap_len_i  (gap_len_i),
        .anod_len_i (anod_len_i),
        .state_o    (state),
        .phase_o    (phase),
        .slot_o     (slot),
        .fetch_o    (fetch)
    );

    hex_amp_fetch #(.ROWS(ROWS), .REPS(REPS), .TW(TW), .AW(AW), .IW(IW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_i    (fetch),
        .phase_i    (phase),
        .slot_i     (slot),
        .amp_data_i (amp_data_i),
        .amp_rd_o   (amp_rd_o),
        .amp_addr_o (amp_addr_o),
        .amp_vld_o  (amp_vld_o),
        .amp_idx_o  (amp_idx_o),
        .amp_o      (amp_o)
    );

    hex_role_map #(.ROWS(ROWS), .REPS(REPS)) u_roles (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (state != ST_IDLE),
        .phase_i  (phase),
        .role_o   (role_o)
    );

    always_comb begin
        case (state)
            ST_CATH: pulse_o = PULSE_CATH;
            ST_GAP:  pulse_o = PULSE_GAP;
            ST_ANOD: pulse_o = PULSE_ANOD;
            default: pulse_o = PULSE_OFF;
        endcase
    end

    assign phase_o = phase;

    // R2: a frame start while idle opens phase 0
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sof_i) |=> (state == ST_LOAD && phase_o == 3'd0));

    // R7: the pulse never starts inside the fetch window of a running read
    a_r7_no_pulse_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        amp_rd_o |-> (pulse_o == PULSE_OFF));

endmodule

// File: tb/hex_stim_scheduler_bench.sv
`timescale 1ns/1ps
module hex_stim_scheduler_bench;

    localparam int ROWS = 7;
    localparam int COLS = 14;
    localparam int N    = 98;
    localparam int IW   = 7;
    localparam int TW   = 16;
    localparam int AW   = 8;
    localparam int K    = 14;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sof_i;
    logic [TW-1:0]     cath_len_i, gap_len_i, anod_len_i;
    logic [AW-1:0]     amp_data;
    logic              amp_rd_o;
    logic [IW-1:0]     amp_addr_o;
    logic              amp_vld_o;
    logic [IW-1:0]     amp_idx_o;
    logic [AW-1:0]     amp_o;
    logic [1:0]        pulse_o;
    logic [2:0]        phase_o;
    logic [2*N-1:0]    role_o;

    always #2.5 clk = ~clk;

    hex_stim_scheduler u_hex_stim_scheduler (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .cath_len_i (cath_len_i),
        .gap_len_i  (gap_len_i),
        .anod_len_i (anod_len_i),
        .amp_data_i (amp_data),
        .amp_rd_o   (amp_rd_o),
        .amp_addr_o (amp_addr_o),
        .amp_vld_o  (amp_vld_o),
        .amp_idx_o  (amp_idx_o),
        .amp_o      (amp_o),
        .pulse_o    (pulse_o),
        .phase_o    (phase_o),
        .role_o     (role_o)
    );

    function automatic int ram_val(input int i);
        return (i * 37 + 11) % 256;
    endfunction

    always_ff @(posedge clk) amp_data <= AW'(ram_val(int'(amp_addr_o)));

    typedef struct {
        int idx;
        int val;
    } item_t;

    item_t exp_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic bit is_ctr(input int q, input int r, input int p);
        return ((q + 3 * r) % 7) == p;
    endfunction

    function automatic bit in_grid(input int q, input int r);
        return q >= 0 && q < COLS && r >= 0 && r < ROWS;
    endfunction

    function automatic logic [2*N-1:0] exp_roles(input int p, input bit act);
        logic [2*N-1:0] v;
        int dq[6] = '{1, -1, 0, 0, 1, -1};
        int dr[6] = '{0, 0, 1, -1, -1, 1};
        v = '0;
        if (act) begin
            for (int i = 0; i < N; i++) begin
                int q, r;
                bit g;
                q = i % COLS;
                r = i / COLS;
                g = 1'b0;
                if (is_ctr(q, r, p)) begin
                    v[2*i +: 2] = 2'b01;
                end else begin
                    for (int k = 0; k < 6; k++)
                        if (in_grid(q + dq[k], r + dr[k]) && is_ctr(q + dq[k], r + dr[k], p))
                            g = 1'b1;
                    v[2*i +: 2] = g ? 2'b10 : 2'b00;
                end
            end
        end
        return v;
    endfunction

    // driver side of the scoreboard: expected amplitude items of one phase (R5, R6)
    task automatic push_phase(input int p);
        for (int i = 0; i < N; i++) begin
            if (is_ctr(i % COLS, i / COLS, p)) begin
                item_t it;
                it.idx = i;
                it.val = ram_val(i);
                exp_q.push_back(it);
            end
        end
    endtask

    // monitor side of the scoreboard (R6)
    always @(negedge clk) begin
        if (rst_n && amp_vld_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected item", 256'(amp_idx_o), 256'(0));
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(int'(amp_idx_o) == e.idx, "R6", "item index", 256'(amp_idx_o), 256'(e.idx));
                chk(int'(amp_o) == e.val, "R6", "item amplitude", 256'(amp_o), 256'(e.val));
            end
        end
    end

    // walks one phase cycle by cycle from the first fetch cycle (R3, R4, R5, R7, R8, R9)
    task automatic check_phase(input int p, input int cl, input int gl, input int al, input int sof_at);
        int ce, ge, ae, total;
        logic [2*N-1:0] vec;
        ce = (cl < 1) ? 1 : cl;
        ge = (gl < 1) ? 1 : gl;
        ae = (al < 1) ? 1 : al;
        total = K + 1 + ce + ge + ae;
        vec = exp_roles(p, 1'b1);
        for (int c = 0; c < total; c++) begin
            int ep;
            if (c < K + 1)           ep = 0;
            else if (c < K + 1 + ce) ep = 1;
            else if (c < K + 1 + ce + ge) ep = 2;
            else                     ep = 3;
            chk(int'(pulse_o) == ep, "R7", "pulse code", 256'(pulse_o), 256'(ep));
            chk(int'(phase_o) == p, "R8", "phase number", 256'(phase_o), 256'(p));
            chk(role_o == vec, "R3_R4", "role vector", 256'(role_o), 256'(vec));
            chk(amp_rd_o == (c < K), "R5", "read strobe", 256'(amp_rd_o), 256'(c < K));
            sof_i = (c == sof_at);
            @(negedge clk);
        end
        sof_i = 1'b0;
    endtask

    task automatic check_idle(input int ncyc, input string req);
        for (int c = 0; c < ncyc; c++) begin
            chk(pulse_o == 2'd0, req, "idle pulse", 256'(pulse_o), 256'(0));
            chk(role_o == '0, req, "idle roles", 256'(role_o), 256'(0));
            chk(amp_rd_o == 1'b0, req, "idle read", 256'(amp_rd_o), 256'(0));
            chk(amp_vld_o == 1'b0, req, "idle item", 256'(amp_vld_o), 256'(0));
            @(negedge clk);
        end
    endtask

    task automatic start_frame();
        sof_i = 1'b1;
        @(negedge clk);
        sof_i = 1'b0;
        chk(phase_o == 3'd0 && pulse_o == 2'd0 && amp_rd_o, "R2", "frame start",
            256'({phase_o, pulse_o, amp_rd_o}), 256'({3'd0, 2'd0, 1'b1}));
    endtask

    task automatic set_lens(input int cl, input int gl, input int al);
        cath_len_i = TW'(cl);
        gap_len_i  = TW'(gl);
        anod_len_i = TW'(al);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual timeout expected frame completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        sof_i = 1'b0;
        set_lens(3, 2, 4);
        repeat (3) @(negedge clk);
        check_idle(2, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(3, "R1");

        // frame A: plain lengths
        for (int p = 0; p < 7; p++) push_phase(p);
        start_frame();
        for (int p = 0; p < 7; p++) check_phase(p, 3, 2, 4, -1);
        check_idle(4, "R8");

        // frame B: zero lengths act as one cycle (R7)
        set_lens(0, 1, 0);
        for (int p = 0; p < 7; p++) push_phase(p);
        start_frame();
        for (int p = 0; p < 7; p++) check_phase(p, 0, 1, 0, -1);
        check_idle(3, "R8");

        // frame C: restart requested during the cathodic part of phase 2 (R9)
        set_lens(2, 3, 2);
        for (int p = 0; p < 3; p++) push_phase(p);
        for (int p = 0; p < 7; p++) push_phase(p);
        start_frame();
        check_phase(0, 2, 3, 2, -1);
        check_phase(1, 2, 3, 2, -1);
        check_phase(2, 2, 3, 2, K + 2);
        for (int p = 0; p < 7; p++) check_phase(p, 2, 3, 2, -1);
        check_idle(3, "R9");

        // frame D: restart requested during the fetch window of phase 4 (R9)
        set_lens(1, 2, 3);
        for (int p = 0; p < 5; p++) push_phase(p);
        for (int p = 0; p < 7; p++) push_phase(p);
        start_frame();
        for (int p = 0; p < 4; p++) check_phase(p, 1, 2, 3, -1);
        check_phase(4, 1, 2, 3, 3);
        for (int p = 0; p < 7; p++) check_phase(p, 1, 2, 3, -1);
        check_idle(3, "R9");

        chk(exp_q.size() == 0, "R6", "items left over", 256'(exp_q.size()), 256'(0));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule